// File: doc/BRIEF.md
# Power Button Override Controller

This block watches an active-low power button and two thermal alarm inputs and turns them into the control strobes for a power-management status register and a sleep-state sequencer. A new press of the button produces a one-cycle request to set the button status bit. Every such press counts as a wake event, and no enable gates it. The button line is asynchronous, so it is synchronized first. The status is raised only on a transition from released to pressed. A status that software clears while the button is still down therefore stays clear until the button is released and pressed again.

A tick input supplies a coarse time base, for example one tick per second. While the button is held, a hold timer counts ticks. When the hold goes past the configured number of ticks, the block issues an override. The override clears the button status, sets the override status, sends a single-cycle request for a forced transition to the soft-off state (S5), and raises a flag that limits wake sources to the button alone. A rising edge on either thermal input causes the same override actions. The wake-restriction flag stays up until the next qualified press.

Top module: `pwrbtn_ovr_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, all outputs are 0. The synchronizer holds the button as released during reset.
- R2: A high-to-low change on `btn_n_i` that stays stable produces exactly one `sts_set_o` pulse, one cycle long. The pulse becomes visible after the third rising clock edge that samples the low level: two synchronizer stages plus one output register.
- R3: `sw_clr_i` high in a cycle produces `sts_clr_o` high in the next cycle. While the button stays held after such a clear, `sts_set_o` does not pulse again. A new pulse needs a release followed by a new press.
- R4: With the synchronized button held, the tick that arrives when HOLD_TICKS ticks have already been counted for the current press fires the override. In the next cycle `ovr_set_o`, `s5_req_o` and `sts_clr_o` are each high for one cycle.
- R5: The hold timer fires at most once per press. Releasing the button resets its count to zero and re-arms it.
- R6: A rising edge of (`therm_trip_i` OR `therm_cat_i`) performs the same one-cycle override actions as R4 in the next cycle. An input that stays high does not repeat them.
- R7: `wake_btn_only_o` goes high together with any override pulse. It falls together with the next `sts_set_o` pulse.
- R8: When an override and a press edge fall in the same cycle, the clear wins: there is no `sts_set_o` pulse, and `sts_clr_o` is high. When a press edge and `sw_clr_i` fall in the same cycle, the set wins: `sts_set_o` pulses and `sts_clr_o` stays low.
- R9: `sts_set_o` and `sts_clr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n_i | input | 1 | Asynchronous power button, low when pressed |
| therm_trip_i | input | 1 | Processor thermal trip level |
| therm_cat_i | input | 1 | Internal thermal catastrophic level |
| sw_clr_i | input | 1 | Software write-one-to-clear strobe for the button status |
| tick_i | input | 1 | One-cycle time-base tick for the hold timer |
| sts_set_o | output | 1 | Pulse: set the button status |
| sts_clr_o | output | 1 | Pulse: clear the button status |
| ovr_set_o | output | 1 | Pulse: set the override status |
| s5_req_o | output | 1 | Pulse: request a forced S5 transition |
| wake_btn_only_o | output | 1 | Level: only the button may wake the system |

## Verification
Two collisions can put a press edge into the same cycle as a second function. In the first, a press edge meets a software clear. In the second, a press edge meets a thermal edge. A long hold cannot fire in the same cycle as its own press edge, so the override collision comes from the thermal inputs. The random phase toggles the button, the clear strobe and both thermal lines often enough that these cycles occur many times. A bench model built from R8 predicts, for each such cycle, which strobe must appear and which must stay low. A directed case lines up a software clear with the press edge.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
  typedef struct packed {
    logic sts_set;
    logic sts_clr;
    logic ovr_set;
    logic s5_req;
  } pbo_act_t;
endpackage

// File: rtl/pbo_sync.sv
module pbo_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RST_VAL;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pbo_hold_timer.sv
module pbo_hold_timer #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic held_i,
  input  logic tick_i,
  output logic fire_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  // Fires on the tick that would take the count beyond the limit.
  assign fire_o = held_i && tick_i && (cnt_q == LIMIT) && !done_q;

  always_ff @(posedge clk) begin
    if (rst || !held_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      if (fire_o) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pbo_action.sv
module pbo_action
  import pbo_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     press_i,
  input  logic     force_i,
  input  logic     sw_clr_i,
  output pbo_act_t act_o,
  output logic     wake_only_o
);
  pbo_act_t nxt;

  always_comb begin
    nxt.sts_set = press_i && !force_i;
    nxt.sts_clr = force_i || (sw_clr_i && !press_i);
    nxt.ovr_set = force_i;
    nxt.s5_req  = force_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o       <= '0;
      wake_only_o <= 1'b0;
    end else begin
      act_o <= nxt;
      if (force_i)      wake_only_o <= 1'b1;
      else if (press_i) wake_only_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwrbtn_ovr_ctrl.sv
module pwrbtn_ovr_ctrl
  import pbo_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n_i,
  input  logic therm_trip_i,
  input  logic therm_cat_i,
  input  logic sw_clr_i,
  input  logic tick_i,
  output logic sts_set_o,
  output logic sts_clr_o,
  output logic ovr_set_o,
  output logic s5_req_o,
  output logic wake_btn_only_o
);
  logic     btn_n_s, held, held_q, press_edge;
  logic     therm_lvl, therm_q, therm_edge;
  logic     hold_fire, force_ovr;
  pbo_act_t act;

  pbo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(btn_n_i), .q_o(btn_n_s)
  );

  assign held      = !btn_n_s;
  assign therm_lvl = therm_trip_i || therm_cat_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= 1'b0;
      therm_q <= 1'b0;
    end else begin
      held_q  <= held;
      therm_q <= therm_lvl;
    end
  end

  assign press_edge = held && !held_q;
  assign therm_edge = therm_lvl && !therm_q;

  pbo_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk(clk), .rst(rst), .held_i(held), .tick_i(tick_i), .fire_o(hold_fire)
  );

  assign force_ovr = hold_fire || therm_edge;

  pbo_action u_act (
    .clk(clk), .rst(rst), .press_i(press_edge), .force_i(force_ovr),
    .sw_clr_i(sw_clr_i), .act_o(act), .wake_only_o(wake_btn_only_o)
  );

  assign sts_set_o = act.sts_set;
  assign sts_clr_o = act.sts_clr;
  assign ovr_set_o = act.ovr_set;
  assign s5_req_o  = act.s5_req;
endmodule

// File: rtl/pbo_checker.sv
module pbo_checker (
  input logic clk,
  input logic rst,
  input logic btn_n_i,
  input logic therm_trip_i,
  input logic therm_cat_i,
  input logic sts_set_o,
  input logic sts_clr_o,
  input logic ovr_set_o,
  input logic s5_req_o,
  input logic wake_btn_only_o
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !(sts_set_o || sts_clr_o || ovr_set_o || s5_req_o || wake_btn_only_o)); // R1

  AST_SET_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    sts_set_o |-> !$past(btn_n_i, 3)); // R2

  AST_HOLD_NEEDS_PRESS: assert property (@(posedge clk) disable iff (rst)
    (s5_req_o && !$past(therm_trip_i || therm_cat_i)) |-> !$past(btn_n_i, 3)); // R4

  AST_WAKE_RISE_OVR: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_btn_only_o) |-> ovr_set_o); // R7

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sts_set_o && sts_clr_o)); // R9
endmodule

bind pwrbtn_ovr_ctrl pbo_checker u_chk (
  .clk(clk), .rst(rst), .btn_n_i(btn_n_i), .therm_trip_i(therm_trip_i),
  .therm_cat_i(therm_cat_i), .sts_set_o(sts_set_o), .sts_clr_o(sts_clr_o),
  .ovr_set_o(ovr_set_o), .s5_req_o(s5_req_o), .wake_btn_only_o(wake_btn_only_o)
);

// File: tb/pwrbtn_ovr_ctrl_tb_top.sv
module pwrbtn_ovr_ctrl_tb_top;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_n = 1'b1, tt = 1'b0, tc = 1'b0, swc = 1'b0, tick = 1'b0;
  logic o_set, o_clr, o_ovr, o_s5, o_wake;

  int n_chk = 0, n_fail = 0;
  int c_set = 0, c_clr = 0, c_s5 = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwrbtn_ovr_ctrl #(.SYNC_STAGES(2), .HOLD_TICKS(HOLD)) dut_i (
    .clk(clk), .rst(rst), .btn_n_i(btn_n), .therm_trip_i(tt), .therm_cat_i(tc),
    .sw_clr_i(swc), .tick_i(tick), .sts_set_o(o_set), .sts_clr_o(o_clr),
    .ovr_set_o(o_ovr), .s5_req_o(o_s5), .wake_btn_only_o(o_wake)
  );

  // Reference model written from the requirements
  logic m_s1, m_s2, m_hq, m_tq, m_done;
  int   m_cnt;
  logic e_set, e_clr, e_ovr, e_wake;
  logic pe, hf, te, fo;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_hq <= 1'b0; m_tq <= 1'b0;
      m_cnt <= 0; m_done <= 1'b0;
      e_set <= 1'b0; e_clr <= 1'b0; e_ovr <= 1'b0; e_wake <= 1'b0;
    end else begin
      pe = !m_s2 && !m_hq;
      hf = !m_s2 && tick && (m_cnt == HOLD) && !m_done;
      te = (tt || tc) && !m_tq;
      fo = hf || te;
      m_s1 <= btn_n; m_s2 <= m_s1; m_hq <= !m_s2; m_tq <= tt || tc;
      if (m_s2) begin
        m_cnt <= 0; m_done <= 1'b0;
      end else begin
        if (tick && m_cnt < HOLD) m_cnt <= m_cnt + 1;
        if (hf) m_done <= 1'b1;
      end
      e_set <= pe && !fo;
      e_clr <= fo || (swc && !pe);
      e_ovr <= fo;
      if (fo) e_wake <= 1'b1;
      else if (pe) e_wake <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (!rst) begin
      chk(o_set == e_set, "R2 sts_set_o", o_set, e_set);
      chk(o_clr == e_clr, "R3 sts_clr_o", o_clr, e_clr);
      chk(o_ovr == e_ovr, "R4 ovr_set_o", o_ovr, e_ovr);
      chk(o_s5 == e_ovr, "R6 s5_req_o", o_s5, e_ovr);
      chk(o_wake == e_wake, "R7 wake_btn_only_o", o_wake, e_wake);
      chk(!(o_set && o_clr), "R9 set/clr exclusive", o_set + o_clr, 1);
    end
    c_set += o_set; c_clr += o_clr; c_s5 += o_s5;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic zero_counts();
    c_set = 0; c_clr = 0; c_s5 = 0;
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    btn_n = 1'b0;                       // held during reset: ignored by R1
    idle(3);
    chk({o_set, o_clr, o_ovr, o_s5, o_wake} == 5'b0, "R1 reset outputs", o_set, 0);
    btn_n = 1'b1;
    @(negedge clk); rst = 1'b0;
    idle(4);
    chk({o_set, o_clr, o_ovr, o_s5, o_wake} == 5'b0, "R1 after reset", o_set, 0);

    // R2 latency: low level visible as sts_set_o after third edge
    btn_n = 1'b0;
    step(); chk(o_set == 1'b0, "R2 edge1", o_set, 0);
    step(); chk(o_set == 1'b0, "R2 edge2", o_set, 0);
    step(); chk(o_set == 1'b1, "R2 edge3", o_set, 1);
    step(); chk(o_set == 1'b0, "R2 one cycle", o_set, 0);

    // R3: clear while held, no re-set
    zero_counts();
    swc = 1'b1; step(); swc = 1'b0;
    chk(o_clr == 1'b1, "R3 clear strobe", o_clr, 1);
    idle(20);
    chk(c_set == 0, "R3 no set while held", c_set, 0);
    btn_n = 1'b1; idle(5);
    zero_counts(); btn_n = 1'b0; idle(5);
    chk(c_set == 1, "R3 re-press sets", c_set, 1);

    // R4/R5: hold past limit, many extra ticks
    zero_counts();
    for (int t = 0; t < 3 * HOLD + 4; t++) begin
      tick = 1'b1; step(); tick = 1'b0; idle(3);
    end
    chk(c_s5 == 1, "R5 single fire per press", c_s5, 1);
    chk(c_clr == 1, "R4 override clears status", c_clr, 1);
    chk(o_wake == 1'b1, "R7 wake restricted", o_wake, 1);

    // R5: release re-arms; HOLD ticks alone must not fire
    btn_n = 1'b1; idle(5); btn_n = 1'b0; idle(4);
    chk(o_wake == 1'b0, "R7 press clears restriction", o_wake, 0);
    zero_counts();
    for (int t = 0; t < HOLD; t++) begin
      tick = 1'b1; step(); tick = 1'b0; idle(2);
    end
    chk(c_s5 == 0, "R4 no fire at limit", c_s5, 0);
    tick = 1'b1; step(); tick = 1'b0; step();
    chk(c_s5 == 1, "R5 fires again after re-arm", c_s5, 1);

    // R6: thermal level held gives one override
    btn_n = 1'b1; idle(5); zero_counts();
    tc = 1'b1; idle(10); tt = 1'b1; idle(5);
    chk(c_s5 == 1, "R6 one override per rise", c_s5, 1);
    tc = 1'b0; tt = 1'b0; idle(3);

    // R8: press edge meets software clear
    zero_counts();
    btn_n = 1'b0; idle(2);
    swc = 1'b1; step(); swc = 1'b0;
    chk(o_set == 1'b1 && o_clr == 1'b0, "R8 set wins over sw clear", o_clr, 0);
    // R8: press edge meets thermal edge
    btn_n = 1'b1; idle(5);
    btn_n = 1'b0; idle(2);
    tt = 1'b1; step();
    chk(o_set == 1'b0 && o_clr == 1'b1, "R8 override wins over press", o_set, 0);
    tt = 1'b0; btn_n = 1'b1; idle(5);

    // Random phase
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(15) == 0) btn_n = ~btn_n;
      if ($urandom_range(60) == 0) tt = ~tt;
      if ($urandom_range(60) == 0) tc = ~tc;
      swc  = ($urandom_range(7) == 0);
      tick = ($urandom_range(3) == 0);
      step();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule